// File: doc/BRIEF.md
# Time-Division Schedule Sequencer with Period-Aligned Mode Switch

This block drives the slot-by-slot activity of a network interface in a time-division multiplexed network. A small table holds one or more complete schedules laid out at different base addresses. Each table entry names a DMA channel and how many consecutive slots that channel owns. An entry pointer walks the active schedule one entry at a time. It stays on an entry for that entry's slot count, so the pointer tracks entries rather than slot numbers. After the entry that carries the end-of-schedule flag, the pointer returns to the start of a schedule and a new period begins.

A mode change is requested by giving a new schedule base address. The request is held until the current period ends. The first slot of the new schedule then follows the last slot of the old one directly, with no idle slot between them. Every interface in the network runs its own copy in lockstep, so a request must always take effect at a period boundary that can be predicted. For that reason, a request that arrives in the final slot of a period waits for the boundary after it. Schedules are loaded through a plain single-entry write port. Each slot the block presents a valid flag, the DMA channel index and a start-of-period pulse.

Top module: `tdm_sched_seq`

## Requirements
- R1: A write with `tbl_we` high stores, at address `tbl_addr`, a DMA index (`tbl_dma`, DMA_W bits), a 4-bit slot count (`tbl_slots`) and an end-of-schedule flag (`tbl_end`). Writes are accepted whether or not reset is asserted.
- R2: Each entry is presented for exactly as many consecutive cycles as its slot count (1 to 15). A stored count of 0 is treated as 1.
- R3: After an entry finishes, the next entry is the one at the following address. After an entry with the end flag finishes, the walk restarts at the base of the active schedule, or at the pending base if a switch is pending.
- R4: `period_start` is high for exactly one cycle: the first slot of every period. It is low in every other slot.
- R5: An entry whose DMA index is all ones is idle: in its slots `slot_valid` is 0 and `slot_dma` is 0. In the slots of any other entry, `slot_valid` is 1 and `slot_dma` carries the entry's index.
- R6: A pulse on `sw_req` latches `sw_base`. The switch takes effect at the end of the current period: the next slot is the first slot of the schedule at the new base, and the schedule then repeats from there. The active schedule never changes in the middle of a period.
- R7: A request sampled in the final slot of a period does not affect the boundary at the end of that slot. It takes effect at the following period boundary.
- R8: A second request made before the boundary replaces the base of an earlier request that is still pending. The last base requested wins.
- R9: `rst_n` is asynchronous and active-low. Its release is synchronised over two clock edges. While reset is in effect, `slot_valid`, `slot_dma` and `period_start` are 0. After release, the walk begins at address 0 with a `period_start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | ADDR_W | Table write address |
| tbl_dma | input | DMA_W | DMA index to store |
| tbl_slots | input | 4 | Slot count to store |
| tbl_end | input | 1 | End-of-schedule flag to store |
| sw_req | input | 1 | Schedule switch request pulse |
| sw_base | input | ADDR_W | Base address of the requested schedule |
| slot_valid | output | 1 | Current slot carries a DMA transfer |
| slot_dma | output | DMA_W | DMA channel of the current slot (0 when not valid) |
| period_start | output | 1 | First slot of a period |

## Verification
On every cycle, the assertions check several invariants. The pointer must hold while an entry is still counting slots. A wrap must land on the base that the switch control reports as active. The active base may change only at a wrap. A request made during a wrap must stay pending. Valid slots must never carry the idle index, and the outputs must stay quiet during reset. Some behaviours can only be shown by the bench's scenarios, because they need the expected slot stream. These are the exact sequence of DMA indices and slot counts across whole periods, the treatment of a zero count, the gap-free handover between schedules of different lengths, and the boundary a request lands on depending on the slot in which it arrives.

// File: rtl/tdm_seq_pkg.sv
package tdm_seq_pkg;

  localparam int SLOT_W = 4;

  typedef logic [SLOT_W-1:0] slot_cnt_t;

  // Last cycle of an entry; a count of 0 behaves as 1.
  function automatic logic slot_is_final(slot_cnt_t idx, slot_cnt_t len);
    return (len <= slot_cnt_t'(1)) || (idx == len - slot_cnt_t'(1));
  endfunction

endpackage

// File: rtl/tdm_sched_table.sv
module tdm_sched_table
  import tdm_seq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DMA_W  = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DMA_W-1:0]  wdma,
  input  slot_cnt_t         wslots,
  input  logic              wend,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DMA_W-1:0]  rdma,
  output slot_cnt_t         rslots,
  output logic              rend
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int ENTRY_W = DMA_W + SLOT_W + 1;

  logic [ENTRY_W-1:0] mem_q [DEPTH];

  // Table storage has no reset; it is loaded through the write port.
  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= {wend, wslots, wdma};
  end

  assign {rend, rslots, rdma} = mem_q[raddr];

endmodule

// File: rtl/tdm_switch_ctrl.sv
module tdm_switch_ctrl #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_base,
  input  logic              wrap,
  output logic [ADDR_W-1:0] next_base,
  output logic [ADDR_W-1:0] act_base
);

  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] pbase_q, pbase_d;
  logic [ADDR_W-1:0] abase_q, abase_d;

  // The base used at the coming wrap reflects only requests already latched.
  assign next_base = pend_q ? pbase_q : abase_q;
  assign act_base  = abase_q;

  always_comb begin
    pend_d  = pend_q;
    pbase_d = pbase_q;
    abase_d = abase_q;
    if (wrap) begin
      abase_d = next_base;
      pend_d  = 1'b0;
    end
    if (req) begin
      pend_d  = 1'b1;
      pbase_d = req_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pbase_q <= '0;
      abase_q <= '0;
    end else begin
      pend_q  <= pend_d;
      pbase_q <= pbase_d;
      abase_q <= abase_d;
    end
  end

  // R6
  base_only_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(abase_q));

  // R7
  late_req_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wrap) |=> pend_q);

  // R6
  pend_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && wrap && !req) |=> !pend_q);

endmodule

// File: rtl/tdm_entry_walker.sv
module tdm_entry_walker
  import tdm_seq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_cnt_t         entry_slots,
  input  logic              entry_end,
  input  logic [ADDR_W-1:0] wrap_base,
  output logic [ADDR_W-1:0] ptr,
  output logic              first_slot,
  output logic              wrap
);

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  slot_cnt_t         sc_q, sc_d;
  logic              head_q, head_d;
  logic              done;

  assign done       = slot_is_final(sc_q, entry_slots);
  assign wrap       = done && entry_end;
  assign ptr        = ptr_q;
  assign first_slot = head_q && (sc_q == '0);

  always_comb begin
    ptr_d  = ptr_q;
    sc_d   = sc_q + slot_cnt_t'(1);
    head_d = head_q;
    if (done) begin
      sc_d   = '0;
      head_d = wrap;
      ptr_d  = wrap ? wrap_base : ptr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      sc_q   <= '0;
      head_q <= 1'b1;
    end else begin
      ptr_q  <= ptr_d;
      sc_q   <= sc_d;
      head_q <= head_d;
    end
  end

  // R2
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(ptr_q));

endmodule

// File: rtl/tdm_sched_seq.sv
module tdm_sched_seq
  import tdm_seq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DMA_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [DMA_W-1:0]  tbl_dma,
  input  logic [3:0]        tbl_slots,
  input  logic              tbl_end,
  input  logic              sw_req,
  input  logic [ADDR_W-1:0] sw_base,
  output logic              slot_valid,
  output logic [DMA_W-1:0]  slot_dma,
  output logic              period_start
);

  localparam logic [DMA_W-1:0] IDLE_IDX = {DMA_W{1'b1}};

  logic              rst_s1_q, rst_s2_q, rs_n;
  logic [ADDR_W-1:0] ptr, next_base, act_base;
  logic [DMA_W-1:0]  ent_dma;
  slot_cnt_t         ent_slots;
  logic              ent_end, first_slot, wrap, ent_idle;

  // Asynchronous assertion, release after two edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rs_n = rst_s2_q;

  tdm_sched_table #(.ADDR_W(ADDR_W), .DMA_W(DMA_W)) i_table (
    .clk    (clk),
    .we     (tbl_we),
    .waddr  (tbl_addr),
    .wdma   (tbl_dma),
    .wslots (tbl_slots),
    .wend   (tbl_end),
    .raddr  (ptr),
    .rdma   (ent_dma),
    .rslots (ent_slots),
    .rend   (ent_end)
  );

  tdm_switch_ctrl #(.ADDR_W(ADDR_W)) i_switch (
    .clk       (clk),
    .rst_n     (rs_n),
    .req       (sw_req),
    .req_base  (sw_base),
    .wrap      (wrap),
    .next_base (next_base),
    .act_base  (act_base)
  );

  tdm_entry_walker #(.ADDR_W(ADDR_W)) i_walker (
    .clk         (clk),
    .rst_n       (rs_n),
    .entry_slots (ent_slots),
    .entry_end   (ent_end),
    .wrap_base   (next_base),
    .ptr         (ptr),
    .first_slot  (first_slot),
    .wrap        (wrap)
  );

  assign ent_idle     = (ent_dma == IDLE_IDX);
  assign slot_valid   = rs_n && !ent_idle;
  assign slot_dma     = slot_valid ? ent_dma : '0;
  assign period_start = rs_n && first_slot;

  // R3
  wrap_lands_on_base_chk: assert property (@(posedge clk) disable iff (!rs_n)
    wrap |=> (ptr == act_base));

  // R5
  idle_never_valid_chk: assert property (@(posedge clk) disable iff (!rs_n)
    slot_valid |-> (slot_dma != IDLE_IDX));

  // R9
  always_comb begin
    if (!rs_n) begin
      quiet_in_reset_chk: assert (!slot_valid && !period_start && slot_dma == '0);
    end
  end

endmodule

// File: tb/test_tdm_sched_seq.sv
module test_tdm_sched_seq;

  localparam int ADDR_W = 5;
  localparam int DMA_W  = 4;
  localparam int BASE_A = 0;
  localparam int BASE_B = 8;
  localparam int BASE_C = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              tbl_we;
  logic [ADDR_W-1:0] tbl_addr;
  logic [DMA_W-1:0]  tbl_dma;
  logic [3:0]        tbl_slots;
  logic              tbl_end;
  logic              sw_req;
  logic [ADDR_W-1:0] sw_base;
  logic              slot_valid;
  logic [DMA_W-1:0]  slot_dma;
  logic              period_start;

  int total = 0;
  int bad   = 0;

  int tb_dma   [32];
  int tb_slots [32];
  int tb_end   [32];
  int e_dma    [512];

  always #5 clk = ~clk;

  tdm_sched_seq #(.ADDR_W(ADDR_W), .DMA_W(DMA_W)) i_tdm_sched_seq (
    .clk (clk), .rst_n (rst_n), .tbl_we (tbl_we), .tbl_addr (tbl_addr),
    .tbl_dma (tbl_dma), .tbl_slots (tbl_slots), .tbl_end (tbl_end),
    .sw_req (sw_req), .sw_base (sw_base), .slot_valid (slot_valid),
    .slot_dma (slot_dma), .period_start (period_start)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d, input int s, input int e);
    tbl_we = 1'b1; tbl_addr = ADDR_W'(a); tbl_dma = DMA_W'(d);
    tbl_slots = 4'(s); tbl_end = e[0];
    tb_dma[a] = d; tb_slots[a] = s; tb_end[a] = e;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // Expected slot stream of one period of the schedule at base b.
  function automatic int build(input int b);
    int n = 0;
    for (int a = b; a < 32; a++) begin
      int cnt = (tb_slots[a] == 0) ? 1 : tb_slots[a];
      for (int j = 0; j < cnt; j++) begin
        e_dma[n] = tb_dma[a];
        n++;
      end
      if (tb_end[a] != 0) break;
    end
    return n;
  endfunction

  task automatic run_period(input int b, input string tag,
                            input int r1_at, input int r1_base,
                            input int r2_at, input int r2_base);
    int len = build(b);
    for (int k = 0; k < len; k++) begin
      logic ev;
      int   ed;
      if (k == r1_at) begin sw_req = 1'b1; sw_base = ADDR_W'(r1_base); end
      if (k == r2_at) begin sw_req = 1'b1; sw_base = ADDR_W'(r2_base); end
      ev = (e_dma[k] != 15);
      ed = ev ? e_dma[k] : 0;
      chk(period_start == (k == 0), {tag, " R4 start"}, int'(period_start), int'(k == 0));
      chk(slot_valid == ev, {tag, " R5 valid"}, int'(slot_valid), int'(ev));
      chk(int'(slot_dma) == ed, {tag, " R2 dma"}, int'(slot_dma), ed);
      @(negedge clk);
      sw_req = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lenb;
    int waited;
    rst_n = 1'b0; tbl_we = 1'b0; tbl_addr = '0; tbl_dma = '0;
    tbl_slots = '0; tbl_end = 1'b0; sw_req = 1'b0; sw_base = '0;
    for (int a = 0; a < 32; a++) begin tb_dma[a] = 0; tb_slots[a] = 1; tb_end[a] = 1; end
    @(negedge clk);
    // R1: load three schedules while reset is held.
    wr(0, 2, 3, 0); wr(1, 5, 1, 0); wr(2, 15, 2, 0); wr(3, 7, 4, 1);
    wr(8, 1, 2, 0); wr(9, 3, 0, 0); wr(10, 9, 5, 1);
    wr(16, 4, 15, 1);
    // R9: quiet outputs during reset
    chk(!slot_valid, "R9 valid in reset", int'(slot_valid), 0);
    chk(!period_start, "R9 start in reset", int'(period_start), 0);
    chk(slot_dma == '0, "R9 dma in reset", int'(slot_dma), 0);
    rst_n = 1'b1;
    waited = 0;
    while (!period_start && waited < 8) begin @(negedge clk); waited++; end
    chk(waited == 2, "R9 release latency", waited, 2);

    run_period(BASE_A, "R9 first A", -1, 0, -1, 0);
    run_period(BASE_A, "R3 wrap A", 3, BASE_B, -1, 0);
    run_period(BASE_B, "R6 switched B", -1, 0, -1, 0);
    lenb = build(BASE_B);
    run_period(BASE_B, "R6 B repeats", lenb - 1, BASE_A, -1, 0);
    run_period(BASE_B, "R7 late req", -1, 0, -1, 0);
    run_period(BASE_A, "R7 applied A", 0, BASE_C, 5, BASE_B);
    run_period(BASE_B, "R8 last wins", 2, BASE_C, -1, 0);
    run_period(BASE_C, "R2 single 15", 14, BASE_A, -1, 0);
    run_period(BASE_C, "R7 late C", -1, 0, -1, 0);
    run_period(BASE_A, "R6 back to A", -1, 0, -1, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule